// File: doc/BRIEF.md
# Auto-Ranging Step-Size Digital Integrator

This block closes the digital side of a single-bit delta-sigma recording loop. On every sample it receives one comparator decision and moves a 12-bit accumulator up (decision 1) or down (decision 0) by a step of 2^E. The accumulator value is the code that drives the loop's feedback DAC, so the accumulator is the running reconstruction of the input.

The exponent E adapts to the recent decision stream. A long run of equal decisions means the reconstruction is lagging a large input, so E grows and the loop slews faster. A stream that keeps alternating means the reconstruction is already tracking, so E shrinks back toward fine resolution. The exponent is also brought out so that downstream logic can scale the reconstructed signal.

Top module: `autorange_integrator`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets `dac_code` to 2048, `step_exp` to 0, and clears the decision history and the alternation count.
- R2: On a clock edge with `sample_en` high, `cmp_bit` = 1 adds 2^`step_exp` to `dac_code` and `cmp_bit` = 0 subtracts it.
- R3: `dac_code` saturates at 4095 when counting up and at 0 when counting down. It never wraps.
- R4: With `sample_en` low, `dac_code`, `step_exp`, the decision history and the alternation count all hold their values, whatever `cmp_bit` is.
- R5: `step_exp` first rises by one on a decision that equals each of the five preceding enabled decisions. This is the sixth equal decision in a row, so a step in the input cannot raise the exponent within its first five samples.
- R6: After R5 is met, every further decision equal to its predecessor raises `step_exp` by one more, up to a ceiling of 7.
- R7: `step_exp` drops by one when four consecutive decisions each differ from the decision before them. The alternation count then restarts, so the next drop needs four fresh alternations.
- R8: `step_exp` never goes below 0. A qualifying alternation at 0 leaves it at 0 and still restarts the count.
- R9: A change of `step_exp` first affects the step of the next enabled sample. The sample that caused the change uses the old exponent.
- R10: Decisions taken before the last reset never count towards R5 or R7. After reset, five zero decisions do not raise the exponent, and the sixth one does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Qualifies a comparator decision on this edge |
| cmp_bit | input | 1 | Comparator decision: 1 counts up, 0 counts down |
| dac_code | output | 12 | Accumulator value driving the feedback DAC |
| step_exp | output | 3 | Current step exponent E, step = 2^E |

## Verification
The bench watches the exact sample on which the exponent first moves after reset. A design that counts five instead of six equal decisions, or that matches against the cleared history, would grow one sample early. It drives runs long enough to reach the ceiling and both rails of the accumulator; a wrapping adder or an unguarded exponent would jump to the opposite end. It checks that the fourth alternation, and not the third, lowers the exponent, and that the count restarts afterwards. It also checks that disabled cycles carrying the opposite decision neither shorten a run nor disturb the accumulator. Long random stretches that mix runs with toggling then compare every sample against a bench model.

// File: rtl/ari_pkg.sv
// Package: shared sizing for the auto-ranging integrator.
// Assumes: consumers derive their own widths from these defaults.
package ari_pkg;
    parameter int ACC_W    = 12;  // accumulator / DAC code width
    parameter int EXP_W    = 3;   // exponent width
    parameter int EXP_MAX  = 7;   // exponent ceiling
    parameter int HIST_LEN = 5;   // stored past decisions
    parameter int ALT_LEN  = 4;   // alternations that trigger a reduction
endpackage

// File: rtl/ari_history.sv
// Module: ari_history
// Keeps the last HIST_LEN enabled comparator decisions (bit 0 newest) and a
// saturating fill count, so decisions from before reset are never trusted.
// Assumes: synchronous active-low reset; updates only when sample_en is high.
module ari_history #(
    parameter int HIST_LEN = ari_pkg::HIST_LEN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic                cmp_bit,
    output logic [HIST_LEN-1:0] hist,
    output logic                hist_full,
    output logic                has_prev
);
    localparam int FILL_W = $clog2(HIST_LEN + 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(HIST_LEN);

    logic [HIST_LEN-1:0] hist_q;
    logic [FILL_W-1:0]   fill_q;

    // Shift the newest decision in at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (sample_en) begin
            hist_q <= {hist_q[HIST_LEN-2:0], cmp_bit};
        end
    end

    // Count valid history entries up to HIST_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (sample_en && fill_q != FILL_MAX) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    // Expose the history and its validity.
    always_comb begin
        hist      = hist_q;
        hist_full = (fill_q == FILL_MAX);
        has_prev  = (fill_q != '0);
    end

    // R4
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(hist_q));

    // R1
    fill_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (fill_q == '0));
endmodule

// File: rtl/ari_exp_ctrl.sv
// Module: ari_exp_ctrl
// Adapts the step exponent: grows on a decision matching a full history of
// equal decisions, shrinks after ALT_LEN consecutive alternations.
// Assumes: history comes from ari_history; a change is used from the next
// enabled sample onwards.
module ari_exp_ctrl #(
    parameter int HIST_LEN = ari_pkg::HIST_LEN,
    parameter int EXP_W    = ari_pkg::EXP_W,
    parameter int EXP_MAX  = ari_pkg::EXP_MAX,
    parameter int ALT_LEN  = ari_pkg::ALT_LEN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic                cmp_bit,
    input  logic [HIST_LEN-1:0] hist,
    input  logic                hist_full,
    input  logic                has_prev,
    output logic [EXP_W-1:0]    exp_out
);
    localparam int ALT_W = $clog2(ALT_LEN + 1);
    localparam logic [ALT_W-1:0] ALT_TRIG = ALT_W'(ALT_LEN);
    localparam logic [EXP_W-1:0] EXP_TOP  = EXP_W'(EXP_MAX);

    logic [EXP_W-1:0] exp_q;
    logic [ALT_W-1:0] alt_q;
    logic [ALT_W-1:0] alt_next;
    logic             grow;
    logic             shrink;
    logic             toggled;

    // Decide grow / shrink from the history and the new decision.
    always_comb begin
        toggled  = has_prev && (cmp_bit != hist[0]);
        grow     = sample_en && hist_full && (hist == {HIST_LEN{cmp_bit}});
        alt_next = toggled ? alt_q + 1'b1 : '0;
        shrink   = sample_en && (alt_next == ALT_TRIG);
    end

    // Track consecutive alternations, restarting after each reduction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alt_q <= '0;
        end else if (sample_en) begin
            alt_q <= (alt_next == ALT_TRIG) ? '0 : alt_next;
        end
    end

    // Move the exponent one step within [0, EXP_MAX].
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
        end else if (grow && exp_q != EXP_TOP) begin
            exp_q <= exp_q + 1'b1;
        end else if (shrink && exp_q != '0) begin
            exp_q <= exp_q - 1'b1;
        end
    end

    assign exp_out = exp_q;

    // R4
    exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(exp_q));

    // R6
    exp_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grow && exp_q == EXP_TOP) |=> (exp_q == EXP_TOP));

    // R8
    exp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shrink && exp_q == '0) |=> (exp_q == '0));

    // R7
    grow_shrink_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grow && shrink));
endmodule

// File: rtl/ari_accum.sv
// Module: ari_accum
// Saturating up/down accumulator with a step of 2^exp.
// Assumes: exp never exceeds ACC_W-1; synchronous active-low reset to mid-scale.
module ari_accum #(
    parameter int ACC_W = ari_pkg::ACC_W,
    parameter int EXP_W = ari_pkg::EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             cmp_bit,
    input  logic [EXP_W-1:0] exp_in,
    output logic [ACC_W-1:0] acc
);
    localparam logic [ACC_W-1:0] ACC_MID = ACC_W'(1) << (ACC_W - 1);
    localparam logic [ACC_W:0]   ACC_TOP = {1'b0, {ACC_W{1'b1}}};

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   step;
    logic [ACC_W:0]   wide;
    logic [ACC_W-1:0] acc_next;

    // Form the saturated next value.
    always_comb begin
        step = {{ACC_W{1'b0}}, 1'b1} << exp_in;
        wide = {1'b0, acc_q};
        if (cmp_bit) begin
            wide     = wide + step;
            acc_next = (wide > ACC_TOP) ? ACC_TOP[ACC_W-1:0] : wide[ACC_W-1:0];
        end else begin
            acc_next = (wide < step) ? '0 : (wide - step);
        end
    end

    // Register the accumulator on enabled samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= ACC_MID;
        end else if (sample_en) begin
            acc_q <= acc_next;
        end
    end

    assign acc = acc_q;

    // R4
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(acc_q));

    // R3
    acc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && cmp_bit && acc_q == ACC_TOP[ACC_W-1:0]) |=> (acc_q == ACC_TOP[ACC_W-1:0]));

    // R3
    acc_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !cmp_bit && acc_q == '0) |=> (acc_q == '0));

    // R2
    acc_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && cmp_bit && acc_q != ACC_TOP[ACC_W-1:0]) |=> (acc_q > $past(acc_q)));

    // R2
    acc_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !cmp_bit && acc_q != '0) |=> (acc_q < $past(acc_q)));
endmodule

// File: rtl/autorange_integrator.sv
// Module: autorange_integrator
// Top of the auto-ranging digital integrator: decision history, exponent
// control and saturating accumulator.
// Assumes: one comparator decision per enabled clock; outputs are registered.
module autorange_integrator #(
    parameter int ACC_W    = ari_pkg::ACC_W,
    parameter int EXP_W    = ari_pkg::EXP_W,
    parameter int EXP_MAX  = ari_pkg::EXP_MAX,
    parameter int HIST_LEN = ari_pkg::HIST_LEN,
    parameter int ALT_LEN  = ari_pkg::ALT_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             cmp_bit,
    output logic [ACC_W-1:0] dac_code,
    output logic [EXP_W-1:0] step_exp
);
    logic [HIST_LEN-1:0] hist;
    logic                hist_full;
    logic                has_prev;
    logic [EXP_W-1:0]    exp_cur;

    ari_history #(.HIST_LEN(HIST_LEN)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .cmp_bit   (cmp_bit),
        .hist      (hist),
        .hist_full (hist_full),
        .has_prev  (has_prev)
    );

    ari_exp_ctrl #(
        .HIST_LEN (HIST_LEN),
        .EXP_W    (EXP_W),
        .EXP_MAX  (EXP_MAX),
        .ALT_LEN  (ALT_LEN)
    ) u_exp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .cmp_bit   (cmp_bit),
        .hist      (hist),
        .hist_full (hist_full),
        .has_prev  (has_prev),
        .exp_out   (exp_cur)
    );

    ari_accum #(.ACC_W(ACC_W), .EXP_W(EXP_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .cmp_bit   (cmp_bit),
        .exp_in    (exp_cur),
        .acc       (dac_code)
    );

    assign step_exp = exp_cur;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (dac_code == (ACC_W'(1) << (ACC_W - 1)) && step_exp == '0));

    // R9
    exp_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> (step_exp == $past(step_exp) || step_exp == $past(step_exp) + 1'b1
                       || step_exp == $past(step_exp) - 1'b1));
endmodule

// File: tb/autorange_integrator_bench.sv
// Bench: directed corner cases plus seeded random decision streams, checked
// against a bench model built from the requirements.
module autorange_integrator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_en = 1'b0;
    logic        cmp_bit = 1'b0;
    logic [11:0] dac_code;
    logic [2:0]  step_exp;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model state
    int m_acc, m_e, m_fill, m_alt;
    bit [4:0] m_hist;

    always #5 clk = ~clk;

    autorange_integrator u_autorange_integrator (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .cmp_bit   (cmp_bit),
        .dac_code  (dac_code),
        .step_exp  (step_exp)
    );

    task automatic check(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int sat_step(input int acc, input int e, input bit d);
        int step = 1 << e;
        if (d) return (acc + step > 4095) ? 4095 : acc + step;
        return (acc < step) ? 0 : acc - step;
    endfunction

    task automatic model_reset();
        m_acc = 2048; m_e = 0; m_fill = 0; m_alt = 0; m_hist = '0;
    endtask

    task automatic model_step(input bit d);
        bit grow, shrink;
        m_acc  = sat_step(m_acc, m_e, d);
        grow   = (m_fill == 5) && (m_hist == {5{d}});
        m_alt  = (m_fill > 0 && d != m_hist[0]) ? m_alt + 1 : 0;
        shrink = (m_alt == 4);
        if (shrink) m_alt = 0;
        if (grow && m_e < 7) m_e++;
        else if (shrink && m_e > 0) m_e--;
        m_hist = {m_hist[3:0], d};
        if (m_fill < 5) m_fill++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sample_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One clock with given enable and decision; compare after the edge.
    task automatic tick(input bit en, input bit d, input string req);
        @(negedge clk);
        sample_en = en; cmp_bit = d;
        @(posedge clk);
        #1;
        if (en) model_step(d);
        check(req, dac_code, m_acc);
        check(req, step_exp, m_e);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R1 reset state
        check("R1 reset dac", dac_code, 2048);
        check("R1 reset exp", step_exp, 0);

        // R5: five ones keep E at 0, sixth raises it; R9 step uses old E
        for (int i = 0; i < 5; i++) tick(1, 1, "R5 run");
        check("R5 exp after five", step_exp, 0);
        check("R2 up by one", dac_code, 2053);
        tick(1, 1, "R5 sixth");
        check("R5 exp after sixth", step_exp, 1);
        check("R9 old step used", dac_code, 2054);
        tick(1, 1, "R9 new step");
        check("R9 step of two", dac_code, 2056);
        check("R6 exp grows", step_exp, 2);
        for (int i = 0; i < 8; i++) tick(1, 1, "R6 climb");
        check("R6 ceiling", step_exp, 7);

        // R7: third alternation keeps E, fourth lowers it, count restarts
        tick(1, 0, "R7 alt1");
        tick(1, 1, "R7 alt2");
        tick(1, 0, "R7 alt3");
        check("R7 no drop at three", step_exp, 7);
        tick(1, 1, "R7 alt4");
        check("R7 drop at four", step_exp, 6);
        for (int i = 0; i < 3; i++) tick(1, i[0], "R7 restart");
        check("R7 count restarted", step_exp, 6);
        tick(1, 1, "R7 second drop");
        check("R7 second drop", step_exp, 5);

        // R3: saturate at the top and the bottom
        for (int i = 0; i < 60; i++) tick(1, 1, "R3 top");
        check("R3 top rail", dac_code, 4095);
        for (int i = 0; i < 80; i++) tick(1, 0, "R3 bottom");
        check("R3 bottom rail", dac_code, 0);

        // R10: after reset, five zeros keep E at 0, sixth raises it
        do_reset();
        for (int i = 0; i < 5; i++) tick(1, 0, "R10 zeros");
        check("R10 no early grow", step_exp, 0);
        check("R2 down by one", dac_code, 2043);
        tick(1, 0, "R10 sixth zero");
        check("R10 grow on sixth", step_exp, 1);

        // R8: alternating at E=0 keeps E at 0
        do_reset();
        for (int i = 0; i < 12; i++) tick(1, i[0], "R8 floor");
        check("R8 exp floor", step_exp, 0);
        check("R8 dac", dac_code, 2048);

        // R4: disabled cycles with opposite decision do not touch state
        do_reset();
        for (int i = 0; i < 3; i++) tick(1, 1, "R4 pre");
        for (int i = 0; i < 4; i++) tick(0, 0, "R4 idle");
        check("R4 dac held", dac_code, 2051);
        check("R4 exp held", step_exp, 0);
        for (int i = 0; i < 3; i++) tick(1, 1, "R4 post");
        check("R4 history intact grow", step_exp, 1);

        // Random: mixed runs and alternation, occasional disables
        do_reset();
        for (int blk = 0; blk < 300; blk++) begin
            int len = 1 + ($urandom % 14);
            bit mode = $urandom % 2;
            bit d = $urandom % 2;
            for (int k = 0; k < len; k++) begin
                bit en = ($urandom % 10) != 0;
                if (mode) d = ~d;
                tick(en, d, "R2 R6 R7 random");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule